// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block moves received 100 Mb/s line data from the recovered receive clock into the 50 MHz reference clock that the MAC samples. On the write side it takes one 2-bit symbol per recovered clock while a carrier/valid flag is high. On the read side it produces the 2-bit receive data and the combined carrier-sense/data-valid signal. The two clocks may differ in frequency. The buffer absorbs the drift over the length of one packet.

A 2-bit tolerance input sets how much slack the buffer holds, measured in bits and counted as dibits. A packet's output starts only after that much data has been buffered. This centres the slack so the buffer can absorb drift in either direction. Larger settings allow longer packets for the same clock mismatch.

A mode input selects the older rule, where carrier-sense stays high until the last dibit. It can instead select the newer rule, where carrier-sense toggles once the end of the packet has been received. Overflow and underflow set sticky status flags, and the rest of the affected packet is discarded.

Top module: `rmii_rx_elastic`

## Requirements
- R1: While no packet is being delivered, and at reset, `rmii_crs_dv` is 0 and `rmii_rxd` is 00. `ovf_sts` and `unf_sts` reset to 0.
- R2: Output of a packet starts once the buffered dibit count reaches the threshold set by `tol_sel`: 00 gives 7 dibits (14 bits), 01 gives 1 dibit (2 bits), 10 gives 3 dibits (6 bits), 11 gives 5 dibits (10 bits). A packet that ends below the threshold is still delivered in full.
- R3: The received dibits come out in write order, one per reference clock, with no gaps, no repeats and no losses.
- R4: With `rev10_mode` = 1, `rmii_crs_dv` is 1 on every cycle that carries data and falls in the cycle after the last dibit. Each packet is one unbroken high burst.
- R5: With `rev10_mode` = 0, once the packet's end has been received, dibits keep coming every cycle. `rmii_crs_dv` is then 0 on even-numbered dibits and 1 on odd-numbered dibits, counting from 0 at the start of the packet, and it is 0 after the last dibit.
- R6: If a write arrives while 15 of the 16 entries are occupied, `ovf_sts` becomes 1. The rest of that packet is dropped, the delivered dibits are an exact prefix of the sent ones, and the next packet is delivered normally.
- R7: If the buffer empties in the middle of a packet, `unf_sts` becomes 1. `rmii_crs_dv` and `rmii_rxd` go to 0, and the rest of that packet is discarded.
- R8: Both status flags are sticky. A one-cycle `sts_clr` pulse clears them at the next reference clock edge, unless a new event arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| rec_clk | input | 1 | Recovered receive clock (write side) |
| rec_dv | input | 1 | Carrier/valid flag for the write-side symbol |
| rec_sym | input | 2 | Received dibit |
| ref_clk | input | 1 | 50 MHz reference clock (read side) |
| tol_sel | input | 2 | Slack/start-threshold select |
| rev10_mode | input | 1 | 1: carrier-sense stays solid; 0: toggles at packet end |
| sts_clr | input | 1 | Clear strobe for the sticky flags (read domain) |
| rmii_rxd | output | 2 | Receive data to the MAC |
| rmii_crs_dv | output | 1 | Carrier sense / data valid to the MAC |
| ovf_sts | output | 1 | Sticky overflow flag |
| unf_sts | output | 1 | Sticky underflow flag |

## Verification
A wrong read pointer or a wrong synchronised write pointer shows at the ports within one packet. It appears as a dibit that differs from the sent sequence, or as a packet that is shorter or longer than sent. A wrong threshold mapping moves the first rise of `rmii_crs_dv` by a whole number of reference cycles. It is caught by comparing start latencies across the tolerance settings at matched clocks. A lost or misplaced end marker shows up as an underflow flag or as a missing carrier-sense drop a few cycles after the write side goes idle. The toggle counting of the newer rule shows up as carrier-sense low on the wrong dibits.

// File: rtl/rmii_eb_pkg.sv
package rmii_eb_pkg;

  // one buffer slot: end-of-packet marker plus a dibit
  typedef struct packed {
    logic       last;
    logic [1:0] sym;
  } eb_entry_t;

  typedef enum logic [1:0] {RS_IDLE, RS_RUN, RS_DROP} rd_state_e;

  // slack in dibits: 00 -> 7, otherwise 2*sel-1 (1, 3, 5)
  function automatic logic [3:0] tol_dibits(input logic [1:0] sel);
    if (sel == 2'b00) return 4'd7;
    return 4'({sel, 1'b1}) - 4'd2;
  endfunction

endpackage

// File: rtl/eb_sync.sv
module eb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
  import rmii_eb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dv,
  input  logic [1:0]            sym,
  input  logic [PW-1:0]         rd_gray_s,
  output logic [PW-1:0]         wr_gray,
  output eb_entry_t [DEPTH-1:0] store,
  output logic                  ovf_tgl
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr, wptr_n, rbin, wfill;
  logic in_pkt, dropping, room;
  logic put_data, put_last, ovf_evt;

  assign rbin  = g2b(rd_gray_s);
  assign wfill = wptr - rbin;
  assign room  = wfill < PW'(DEPTH - 1);   // one slot kept for the end marker

  always_comb begin
    put_data = dv && !dropping && room;
    ovf_evt  = dv && !dropping && !room;
    put_last = ovf_evt || (!dv && in_pkt);
    wptr_n   = (put_data || put_last) ? wptr + 1'b1 : wptr;
  end

  always_ff @(posedge clk) begin
    if (put_data || put_last) begin
      store[wptr[AW-1:0]].last <= put_last;
      store[wptr[AW-1:0]].sym  <= put_last ? 2'b00 : sym;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wr_gray  <= '0;
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
      ovf_tgl  <= 1'b0;
    end else begin
      wptr     <= wptr_n;
      wr_gray  <= wptr_n ^ (wptr_n >> 1);
      in_pkt   <= put_data ? 1'b1 : (put_last ? 1'b0 : in_pkt);
      dropping <= dv && (dropping || ovf_evt);
      if (ovf_evt) ovf_tgl <= ~ovf_tgl;
    end
  end

  // R6: occupancy seen by the writer never exceeds the storage
  a_r6_never_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    wfill <= PW'(DEPTH));
  // R6: once a packet overflowed, nothing more of it is stored
  a_r6_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && dv) |=> (wptr == $past(wptr)));
endmodule

// File: rtl/eb_rd_side.sv
module eb_rd_side
  import rmii_eb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            tol_sel,
  input  logic                  rev10,
  input  logic                  sts_clr,
  input  logic [PW-1:0]         wr_gray_s,
  input  eb_entry_t [DEPTH-1:0] store,
  input  logic                  ovf_tgl_s,
  output logic [PW-1:0]         rd_gray,
  output logic [1:0]            rxd,
  output logic                  crs_dv,
  output logic                  ovf_sts,
  output logic                  unf_sts
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_state_e st, st_n;
  logic [PW-1:0] rptr, rptr_n, wbin, fill, thr;
  logic idx, idx_n, dv_q, dv_n, tail_q, tail_n, crs_n;
  logic [1:0] rxd_n;
  logic last_pend, unf_evt, ovf_evt, tgl_d;
  eb_entry_t head;

  assign wbin    = g2b(wr_gray_s);
  assign fill    = wbin - rptr;
  assign thr     = PW'(tol_dibits(tol_sel));
  assign head    = store[rptr[AW-1:0]];
  assign ovf_evt = ovf_tgl_s ^ tgl_d;

  // end marker already present among the occupied slots
  always_comb begin
    last_pend = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (PW'(i) < fill && store[AW'(rptr + PW'(i))].last) last_pend = 1'b1;
    end
  end

  always_comb begin
    st_n = st; rptr_n = rptr; idx_n = idx;
    rxd_n = 2'b00; crs_n = 1'b0; dv_n = 1'b0; unf_evt = 1'b0;
    case (st)
      RS_IDLE: begin
        idx_n = 1'b0;
        if (fill != '0 && (fill >= thr || last_pend)) st_n = RS_RUN;
      end
      RS_RUN: begin
        if (fill == '0) begin
          unf_evt = 1'b1;
          st_n    = RS_DROP;
        end else begin
          rptr_n = rptr + 1'b1;
          if (head.last) st_n = RS_IDLE;
          else begin
            rxd_n = head.sym;
            dv_n  = 1'b1;
            crs_n = rev10 || !last_pend || idx;
            idx_n = ~idx;
          end
        end
      end
      RS_DROP: begin
        if (fill != '0) begin
          rptr_n = rptr + 1'b1;
          if (head.last) st_n = RS_IDLE;
        end
      end
      default: st_n = RS_IDLE;
    endcase
    tail_n = dv_n && !rev10 && last_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_IDLE; rptr <= '0; rd_gray <= '0; idx <= 1'b0;
      rxd <= 2'b00; crs_dv <= 1'b0; dv_q <= 1'b0; tail_q <= 1'b0;
      tgl_d <= 1'b0; ovf_sts <= 1'b0; unf_sts <= 1'b0;
    end else begin
      st      <= st_n;
      rptr    <= rptr_n;
      rd_gray <= rptr_n ^ (rptr_n >> 1);
      idx     <= idx_n;
      rxd     <= rxd_n;
      crs_dv  <= crs_n;
      dv_q    <= dv_n;
      tail_q  <= tail_n;
      tgl_d   <= ovf_tgl_s;
      ovf_sts <= ovf_evt || (ovf_sts && !sts_clr);
      unf_sts <= unf_evt || (unf_sts && !sts_clr);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_IDLE && $past(st) == RS_IDLE) |-> (!crs_dv && rxd == 2'b00));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr == $past(rptr)) || (rptr == $past(rptr) + 1'b1));
  a_r3_within_written: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH));
  a_r4_solid_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (rev10 && dv_q) |-> crs_dv);
  a_r5_tail_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q && $past(tail_q)) |-> (crs_dv != $past(crs_dv)));
  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_sts);
  a_r7_unf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (unf_sts && !crs_dv));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !unf_evt && !ovf_evt) |=> (!unf_sts && !ovf_sts));
endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
  import rmii_eb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       arst_n,
  input  logic       rec_clk,
  input  logic       rec_dv,
  input  logic [1:0] rec_sym,
  input  logic       ref_clk,
  input  logic [1:0] tol_sel,
  input  logic       rev10_mode,
  input  logic       sts_clr,
  output logic [1:0] rmii_rxd,
  output logic       rmii_crs_dv,
  output logic       ovf_sts,
  output logic       unf_sts
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  eb_entry_t [DEPTH-1:0] store;
  logic [PW-1:0] wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic ovf_tgl, ovf_tgl_s;

  eb_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(rec_clk), .rst_n(arst_n), .dv(rec_dv), .sym(rec_sym),
    .rd_gray_s(rd_gray_s), .wr_gray(wr_gray), .store(store), .ovf_tgl(ovf_tgl));

  eb_sync #(.W(PW)) u_sync_w2r (
    .clk(ref_clk), .rst_n(arst_n), .d(wr_gray), .q(wr_gray_s));

  eb_sync #(.W(PW)) u_sync_r2w (
    .clk(rec_clk), .rst_n(arst_n), .d(rd_gray), .q(rd_gray_s));

  eb_sync #(.W(1)) u_sync_ovf (
    .clk(ref_clk), .rst_n(arst_n), .d(ovf_tgl), .q(ovf_tgl_s));

  eb_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(ref_clk), .rst_n(arst_n), .tol_sel(tol_sel), .rev10(rev10_mode),
    .sts_clr(sts_clr), .wr_gray_s(wr_gray_s), .store(store), .ovf_tgl_s(ovf_tgl_s),
    .rd_gray(rd_gray), .rxd(rmii_rxd), .crs_dv(rmii_crs_dv),
    .ovf_sts(ovf_sts), .unf_sts(unf_sts));
endmodule

// File: tb/tb_rmii_rx_elastic.sv
`timescale 1ns/1ps
module tb_rmii_rx_elastic;
  logic arst_n = 1'b0, rec_clk = 1'b0, ref_clk = 1'b0;
  logic rec_dv = 1'b0, rev10_mode = 1'b1, sts_clr = 1'b0;
  logic [1:0] rec_sym = 2'b00, tol_sel = 2'b01;
  logic [1:0] rmii_rxd;
  logic rmii_crs_dv, ovf_sts, unf_sts;

  rmii_rx_elastic dut (.*);

  real wr_half = 10.0;
  always #10 ref_clk = ~ref_clk;
  initial begin #3; forever #(wr_half) rec_clk = ~rec_clk; end

  int tests = 0, fails = 0;
  logic [1:0] exp_q[$];
  int got_cnt = 0, low_cnt = 0, pkt_cnt = 0, idle_bad = 0;
  realtime t_first, t_rise;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sym_of(input int i, input int seed);
    return 2'((i * 5 + seed * 3 + (i >> 2)) & 3);
  endfunction

  // driver: writes symbols and pushes the expected items
  task automatic send_pkt(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge rec_clk);
      if (i == 0) t_first = $realtime;
      rec_dv = 1'b1;
      rec_sym = sym_of(i, seed);
      exp_q.push_back(sym_of(i, seed));
    end
    @(negedge rec_clk); rec_dv = 1'b0; rec_sym = 2'b00;
    repeat (3) @(negedge rec_clk);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // monitor: a low carrier cycle carries data only when inside a packet and followed by high
  logic p_crs = 1'b0, p_in = 1'b0;
  logic [1:0] p_rxd = 2'b00;
  always @(negedge ref_clk) begin
    logic c, take, now_in;
    logic [1:0] e;
    if (arst_n) begin
      c = rmii_crs_dv;
      take = p_crs || (p_in && c);
      if (take) begin
        got_cnt++;
        if (!p_crs) low_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected dibit", int'(p_rxd), -1);
        else begin
          e = exp_q.pop_front();
          check(p_rxd == e, "R3", "dibit order", int'(p_rxd), int'(e));
        end
      end
      now_in = c || (p_in && p_crs);
      if (now_in && !p_in) begin pkt_cnt++; t_rise = $realtime; end
      if (!now_in && !c && rmii_rxd != 2'b00) idle_bad++;
      p_crs = c; p_rxd = rmii_rxd; p_in = now_in;
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    real lat01, lat10, lat11, lat00;
    int g0, p0, l0;
    #95 arst_n = 1'b1;
    idle_wait(4);
    check(rmii_crs_dv == 1'b0, "R1", "reset crs_dv", int'(rmii_crs_dv), 0);
    check(rmii_rxd == 2'b00, "R1", "reset rxd", int'(rmii_rxd), 0);
    check(ovf_sts == 1'b0, "R1", "reset ovf", int'(ovf_sts), 0);
    check(unf_sts == 1'b0, "R1", "reset unf", int'(unf_sts), 0);

    // R2/R4: start latency per setting, solid carrier
    tol_sel = 2'b01; p0 = pkt_cnt; l0 = low_cnt;
    send_pkt(20, 1); idle_wait(60);
    lat01 = t_rise - t_first;
    check(exp_q.size() == 0, "R3", "leftover", exp_q.size(), 0);
    check(low_cnt == l0, "R4", "data on low carrier", low_cnt - l0, 0);
    check(pkt_cnt == p0 + 1, "R4", "bursts per packet", pkt_cnt - p0, 1);
    tol_sel = 2'b10; send_pkt(20, 2); idle_wait(60); lat10 = t_rise - t_first;
    tol_sel = 2'b11; send_pkt(20, 3); idle_wait(60); lat11 = t_rise - t_first;
    tol_sel = 2'b00; send_pkt(20, 4); idle_wait(60); lat00 = t_rise - t_first;
    check((lat10 - lat01) > 20.0 && (lat10 - lat01) < 60.0, "R2", "sel10 extra ns",
          int'(lat10 - lat01), 40);
    check((lat11 - lat01) > 60.0 && (lat11 - lat01) < 100.0, "R2", "sel11 extra ns",
          int'(lat11 - lat01), 80);
    check((lat00 - lat01) > 100.0 && (lat00 - lat01) < 140.0, "R2", "sel00 extra ns",
          int'(lat00 - lat01), 120);

    // R2: short packet under the threshold still delivered
    g0 = got_cnt; send_pkt(4, 5); idle_wait(60);
    check(got_cnt - g0 == 4, "R2", "short packet dibits", got_cnt - g0, 4);

    // R5: toggling carrier at packet end
    rev10_mode = 1'b0; p0 = pkt_cnt; l0 = low_cnt;
    send_pkt(40, 6); idle_wait(60);
    check(low_cnt - l0 >= 2, "R5", "data on low carrier", low_cnt - l0, 3);
    check(pkt_cnt == p0 + 1, "R5", "packets seen", pkt_cnt - p0, 1);
    check(exp_q.size() == 0, "R5", "leftover", exp_q.size(), 0);
    tol_sel = 2'b01; send_pkt(8, 7); idle_wait(60);
    check(exp_q.size() == 0, "R5", "leftover short", exp_q.size(), 0);

    // R3: 1% slower writer absorbed by the largest slack
    rev10_mode = 1'b1; tol_sel = 2'b00; wr_half = 10.1;
    send_pkt(200, 8); idle_wait(60);
    check(exp_q.size() == 0, "R3", "drift leftover", exp_q.size(), 0);
    check(unf_sts == 1'b0, "R3", "drift underflow", int'(unf_sts), 0);

    // R6: fast writer overflows
    tol_sel = 2'b01; wr_half = 5.0; g0 = got_cnt;
    send_pkt(80, 9); idle_wait(80);
    check(ovf_sts == 1'b1, "R6", "overflow flag", int'(ovf_sts), 1);
    check(got_cnt - g0 < 80 && got_cnt - g0 >= 10, "R6", "prefix length", got_cnt - g0, 40);
    exp_q.delete();
    idle_wait(10);
    check(ovf_sts == 1'b1, "R8", "overflow sticky", int'(ovf_sts), 1);
    sts_clr = 1'b1; idle_wait(1); sts_clr = 1'b0;
    check(ovf_sts == 1'b0, "R8", "overflow cleared", int'(ovf_sts), 0);
    wr_half = 10.0; idle_wait(10);
    send_pkt(24, 10); idle_wait(60);
    check(exp_q.size() == 0, "R6", "recovery leftover", exp_q.size(), 0);
    check(ovf_sts == 1'b0, "R6", "recovery no overflow", int'(ovf_sts), 0);

    // R7: slow writer underflows
    tol_sel = 2'b00; wr_half = 20.0; g0 = got_cnt;
    send_pkt(60, 11); idle_wait(80);
    check(unf_sts == 1'b1, "R7", "underflow flag", int'(unf_sts), 1);
    check(ovf_sts == 1'b0, "R7", "no overflow", int'(ovf_sts), 0);
    check(got_cnt - g0 < 60, "R7", "rest dropped", got_cnt - g0, 20);
    check(rmii_crs_dv == 1'b0, "R7", "carrier low", int'(rmii_crs_dv), 0);
    exp_q.delete();
    sts_clr = 1'b1; idle_wait(1); sts_clr = 1'b0;
    check(unf_sts == 1'b0, "R8", "underflow cleared", int'(unf_sts), 0);

    check(idle_bad == 0, "R1", "idle rxd nonzero cycles", idle_bad, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule